// File: doc/BRIEF.md
# Serial Flash Geometry Identifier

This block runs once after power-up, or whenever software-independent start logic pulses `start`, to work out the organisation of an attached serial page-based flash. It does not move bits on the serial wires itself. Instead it asks a neighbouring byte engine for two kinds of answer: the three-byte manufacturer/device identifier, and the one-byte status register. From those answers it produces the number of pages, the bytes per page and the page-address shift that the rest of the flash controller uses to form addresses.

Identification has two paths. When the first identifier byte names the expected manufacturer, the identifier is looked up in a built-in table. Several table entries describe parts that can be strapped for either a binary (power-of-two) page or a slightly larger legacy page, and for those a status read settles which one is in use. When the manufacturer byte is anything else, the part is assumed to be an older one that only reports its density through a code in the status byte, and the block decodes that code instead. At the end either a geometry is presented with `geoValid`, or `notFound` is raised. The result holds until the next accepted start.

Top module: `flash_geom_id`

## Requirements
- R1: After reset `geoValid`, `notFound`, `idReq`, `statReq` are low and `pageCount`, `pageSize`, `addrShift` are zero.
- R2: A `start` pulse while idle clears both result flags and all three geometry fields on that clock edge and then raises `idReq` for exactly one cycle.
- R3: When the identifier answer is 0x1F2700 (first byte in bits 23:16), the block reports 8192 pages of 528 bytes with shift 10 and never raises `statReq`.
- R4: For an identifier with a two-mode entry, the block raises `statReq` once; status bit 0 at 1 selects the binary geometry and bit 0 at 0 selects the legacy geometry.
- R5: Table for manufacturer byte 0x1F, giving pages, legacy size/shift, binary size/shift: 0x1F2200: 512, 264/9, 256/8; 0x1F2300: 1024, 264/9, 256/8; 0x1F2400: 2048, 264/9, 256/8; 0x1F2500: 4096, 264/9, 256/8; 0x1F2600 and 0x1F2701: 4096 resp. 8192, 528/10, 512/9; 0x1F2800: 8192, 1056/11, 1024/10.
- R6: An identifier whose first byte is 0x1F but which is absent from the table ends with `notFound` and no status read.
- R7: An identifier whose first byte differs from 0x1F leads to one status read; the code (status AND 0x3C) maps 0x0C, 0x14, 0x1C, 0x24 to 512, 1024, 2048, 4096 pages of 264 bytes with shift 9; 0x2C to 4096 × 528 shift 10; 0x34 to 8192 × 528 shift 10; 0x38 and 0x3C to 8192 × 1056 shift 11.
- R8: On the status path a status of 0x00 or 0xFF ends with `notFound`.
- R9: On the status path any other code than those of R7 ends with `notFound`.
- R10: Results hold until the next accepted start; `start` while a run is in progress and answers arriving while none is awaited change nothing.
- R11: A run ends with exactly one of `geoValid` and `notFound` high, one clock edge after the last answer was accepted (or after the identifier was accepted when no status read follows).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin identification (ignored unless idle) |
| idReq | output | 1 | One-cycle request for the 3-byte identifier read |
| idValid | input | 1 | Identifier answer present |
| idData | input | 24 | Identifier, first received byte in bits 23:16 |
| statReq | output | 1 | One-cycle request for a status byte read |
| statValid | input | 1 | Status answer present |
| statData | input | 8 | Status byte |
| geoValid | output | 1 | Geometry fields are valid |
| notFound | output | 1 | No usable part identified |
| pageCount | output | 14 | Number of pages |
| pageSize | output | 11 | Bytes per page |
| addrShift | output | 4 | Page-number shift inside the flash address |

## Verification
The bench targets the fork between the two paths: a design that tested the wrong identifier byte would send a known part to the status decode, and one that treated an unlisted 0x1F identifier as a fallback would read status instead of failing. It covers both values of status bit 0 on several two-mode parts, and the single-mode 0x1F2700 entry, where a design that read status anyway would show up as an unexpected status request. On the status path it walks every supported density code including both 0x38 and 0x3C, plus 0x00, 0xFF and an unlisted code, which a loose mask would map to a geometry. Stray starts and answers outside their window check that a run is not restarted and a held result is not overwritten.

// File: rtl/flash_geom_pkg.sv
package flash_geom_pkg;
  parameter int PAGES_W = 14;
  parameter int SIZE_W  = 11;
  parameter int SHIFT_W = 4;
  parameter int ID_W    = 24;
  parameter int STAT_W  = 8;
  parameter logic [7:0] MFG_CODE = 8'h1F;

  typedef struct packed {
    logic [PAGES_W-1:0] pages;
    logic [SIZE_W-1:0]  size;
    logic [SHIFT_W-1:0] shift;
  } geom_t;

  typedef struct packed {
    logic  hit;
    logic  dual;
    geom_t legacyGeo;
    geom_t binGeo;
  } idEntry_t;

  typedef struct packed {
    logic clear;
    logic capId;
    logic capStat;
    logic commit;
    logic useLegacy;
    logic miss;
  } ctlStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ID_ISSUE, S_ID_WAIT, S_DECIDE, S_ST_ISSUE, S_ST_WAIT, S_FINISH
  } idState_e;

  function automatic geom_t mkGeo(input int pg, input int sz, input int sh);
    geom_t g;
    g.pages = PAGES_W'(pg);
    g.size  = SIZE_W'(sz);
    g.shift = SHIFT_W'(sh);
    return g;
  endfunction

  function automatic idEntry_t lookupId(input logic [ID_W-1:0] id);
    idEntry_t e;
    e = '0;
    e.hit  = 1'b1;
    e.dual = 1'b1;
    case (id)
      24'h1F2200: begin e.legacyGeo = mkGeo(512, 264, 9);   e.binGeo = mkGeo(512, 256, 8);   end
      24'h1F2300: begin e.legacyGeo = mkGeo(1024, 264, 9);  e.binGeo = mkGeo(1024, 256, 8);  end
      24'h1F2400: begin e.legacyGeo = mkGeo(2048, 264, 9);  e.binGeo = mkGeo(2048, 256, 8);  end
      24'h1F2500: begin e.legacyGeo = mkGeo(4096, 264, 9);  e.binGeo = mkGeo(4096, 256, 8);  end
      24'h1F2600: begin e.legacyGeo = mkGeo(4096, 528, 10); e.binGeo = mkGeo(4096, 512, 9);  end
      24'h1F2700: begin e.legacyGeo = mkGeo(8192, 528, 10); e.dual = 1'b0;                    end
      24'h1F2701: begin e.legacyGeo = mkGeo(8192, 528, 10); e.binGeo = mkGeo(8192, 512, 9);  end
      24'h1F2800: begin e.legacyGeo = mkGeo(8192, 1056, 11); e.binGeo = mkGeo(8192, 1024, 10); end
      default:    begin e.hit = 1'b0; e.dual = 1'b0; end
    endcase
    return e;
  endfunction

  function automatic logic decodeDensity(input logic [STAT_W-1:0] st, output geom_t g);
    logic ok;
    ok = 1'b1;
    g  = '0;
    if (st == '0 || st == '1) ok = 1'b0;
    else begin
      case (st & 8'h3C)
        8'h0C: g = mkGeo(512, 264, 9);
        8'h14: g = mkGeo(1024, 264, 9);
        8'h1C: g = mkGeo(2048, 264, 9);
        8'h24: g = mkGeo(4096, 264, 9);
        8'h2C: g = mkGeo(4096, 528, 10);
        8'h34: g = mkGeo(8192, 528, 10);
        8'h38, 8'h3C: g = mkGeo(8192, 1056, 11);
        default: ok = 1'b0;
      endcase
    end
    return ok;
  endfunction
endpackage

// File: rtl/flash_geom_dp.sv
module flash_geom_dp
  import flash_geom_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  logic [ID_W-1:0]    idData,
  input  logic [STAT_W-1:0]  statData,
  output logic               mfgOk,
  output logic               idHit,
  output logic               idDual,
  output logic               legacyOk,
  output logic               geoValid,
  output logic               notFound,
  output geom_t              geo
);
  logic [ID_W-1:0]   idReg;
  logic [STAT_W-1:0] statReg;
  idEntry_t          entry;
  geom_t             legGeo;
  geom_t             pickGeo;

  always_comb begin
    entry    = lookupId(idReg);
    legacyOk = decodeDensity(statReg, legGeo);
    mfgOk    = (idReg[ID_W-1 -: 8] == MFG_CODE);
    idHit    = entry.hit;
    idDual   = entry.dual;
    if (ctl.useLegacy)                pickGeo = legGeo;
    else if (entry.dual && statReg[0]) pickGeo = entry.binGeo;
    else                               pickGeo = entry.legacyGeo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg    <= '0;
      statReg  <= '0;
      geoValid <= 1'b0;
      notFound <= 1'b0;
      geo      <= '0;
    end else begin
      if (ctl.clear) begin
        geoValid <= 1'b0;
        notFound <= 1'b0;
        geo      <= '0;
        statReg  <= '0;
      end
      if (ctl.capId)   idReg   <= idData;
      if (ctl.capStat) statReg <= statData;
      if (ctl.commit) begin
        if (ctl.miss) notFound <= 1'b1;
        else begin
          geoValid <= 1'b1;
          geo      <= pickGeo;
        end
      end
    end
  end

  // R11: a commit leaves exactly one result flag high
  p_one_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> (geoValid ^ notFound));
  // R11: the two flags never coexist
  p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(geoValid && notFound));
  // R10: a valid geometry stays put until a clear
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (geoValid && !ctl.clear) |=> (geoValid && $stable(geo)));
  // R5: page size fits the shift window
  p_geo_shape_r5: assert property (@(posedge clk) disable iff (!rstN)
    geoValid |-> ((32'(geo.size) <= (32'd1 << geo.shift)) &&
                  (32'(geo.size) >  (32'd1 << (geo.shift - 1)))));
endmodule

// File: rtl/flash_geom_ctrl.sv
module flash_geom_ctrl
  import flash_geom_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       idValid,
  input  logic       statValid,
  input  logic       mfgOk,
  input  logic       idHit,
  input  logic       idDual,
  input  logic       legacyOk,
  output logic       idReq,
  output logic       statReq,
  output ctlStrobe_t ctl
);
  idState_e state, nxt;
  logic     legacyPath, legacyNxt;

  always_comb begin
    ctl       = '0;
    nxt       = state;
    legacyNxt = legacyPath;
    case (state)
      S_IDLE: if (start) begin
        ctl.clear = 1'b1;
        nxt       = S_ID_ISSUE;
      end
      S_ID_ISSUE: nxt = S_ID_WAIT;
      S_ID_WAIT: if (idValid) begin
        ctl.capId = 1'b1;
        nxt       = S_DECIDE;
      end
      S_DECIDE: begin
        legacyNxt = !mfgOk;
        if (!mfgOk || idDual) nxt = S_ST_ISSUE;
        else begin
          ctl.commit = 1'b1;
          ctl.miss   = !idHit;
          nxt        = S_IDLE;
        end
      end
      S_ST_ISSUE: nxt = S_ST_WAIT;
      S_ST_WAIT: if (statValid) begin
        ctl.capStat = 1'b1;
        nxt         = S_FINISH;
      end
      S_FINISH: begin
        ctl.commit    = 1'b1;
        ctl.useLegacy = legacyPath;
        ctl.miss      = legacyPath && !legacyOk;
        nxt           = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      legacyPath <= 1'b0;
    end else begin
      state      <= nxt;
      legacyPath <= legacyNxt;
    end
  end

  assign idReq   = (state == S_ID_ISSUE);
  assign statReq = (state == S_ST_ISSUE);

  // R2: identifier request is a single-cycle pulse
  p_idreq_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    idReq |=> !idReq);
  // R4: status request is a single-cycle pulse
  p_streq_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    statReq |=> !statReq);
endmodule

// File: rtl/flash_geom_id.sv
module flash_geom_id
  import flash_geom_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  output logic               idReq,
  input  logic               idValid,
  input  logic [ID_W-1:0]    idData,
  output logic               statReq,
  input  logic               statValid,
  input  logic [STAT_W-1:0]  statData,
  output logic               geoValid,
  output logic               notFound,
  output logic [PAGES_W-1:0] pageCount,
  output logic [SIZE_W-1:0]  pageSize,
  output logic [SHIFT_W-1:0] addrShift
);
  ctlStrobe_t ctl;
  logic       mfgOk, idHit, idDual, legacyOk;
  geom_t      geo;

  flash_geom_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .idValid(idValid),
    .statValid(statValid), .mfgOk(mfgOk), .idHit(idHit), .idDual(idDual),
    .legacyOk(legacyOk), .idReq(idReq), .statReq(statReq), .ctl(ctl)
  );

  flash_geom_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .idData(idData), .statData(statData),
    .mfgOk(mfgOk), .idHit(idHit), .idDual(idDual), .legacyOk(legacyOk),
    .geoValid(geoValid), .notFound(notFound), .geo(geo)
  );

  assign pageCount = geo.pages;
  assign pageSize  = geo.size;
  assign addrShift = geo.shift;
endmodule

// File: tb/flash_geom_id_tb.sv
module flash_geom_id_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic idValid = 1'b0;
  logic [23:0] idData = '0;
  logic statValid = 1'b0;
  logic [7:0] statData = '0;
  logic idReq, statReq, geoValid, notFound;
  logic [13:0] pageCount;
  logic [10:0] pageSize;
  logic [3:0]  addrShift;

  always #2 clk = ~clk;

  flash_geom_id u_dut (
    .clk(clk), .rstN(rstN), .start(start), .idReq(idReq), .idValid(idValid),
    .idData(idData), .statReq(statReq), .statValid(statValid), .statData(statData),
    .geoValid(geoValid), .notFound(notFound), .pageCount(pageCount),
    .pageSize(pageSize), .addrShift(addrShift)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string curTag = "R1";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference
  int  mPhase = 0;
  int  mId = 0;
  bit  pend = 0;
  bit  pMiss = 0;
  int  pPg = 0, pSz = 0, pSh = 0;
  bit  eVal = 0, eMiss = 0;
  int  ePg = 0, eSz = 0, eSh = 0;

  function automatic void jedModel(input int id, input int st, output bit known,
                                   output bit needSt, output int pg, output int sz, output int sh);
    int dens, rev;
    dens = (id >> 8) & 255;
    rev  = id & 255;
    known  = ((id >> 16) == 'h1F) && ((dens >= 'h22 && dens <= 'h28 && rev == 0) || (dens == 'h27 && rev == 1));
    needSt = known && (id != 'h1F2700);
    if (dens <= 'h25) pg = 512 << (dens - 'h22);
    else if (dens == 'h26) pg = 4096;
    else pg = 8192;
    sh = (dens <= 'h25) ? 9 : (dens == 'h28 ? 11 : 10);
    sz = (dens <= 'h25) ? 264 : (dens == 'h28 ? 1056 : 528);
    if (needSt && st[0]) begin
      sh = sh - 1;
      sz = 1 << sh;
    end
  endfunction

  function automatic bit legModel(input int s, output int pg, output int sz, output int sh);
    int c;
    c = (s >> 2) & 15;
    pg = 0; sz = 0; sh = 0;
    if (s == 0 || s == 255) return 0;
    if (c == 3 || c == 5 || c == 7 || c == 9) begin pg = 512 << ((c - 3) / 2); sz = 264; sh = 9; return 1; end
    if (c == 11) begin pg = 4096; sz = 528; sh = 10; return 1; end
    if (c == 13) begin pg = 8192; sz = 528; sh = 10; return 1; end
    if (c == 14 || c == 15) begin pg = 8192; sz = 1056; sh = 11; return 1; end
    return 0;
  endfunction

  always @(posedge clk) begin
    bit doPend, kn, ns, ok;
    int a, b, c;
    cycles++;
    if (!rstN) begin
      mPhase = 0; pend = 0; eVal = 0; eMiss = 0; ePg = 0; eSz = 0; eSh = 0;
    end else begin
      doPend = pend;
      pend = 0;
      if (mPhase == 0 && start) begin
        eVal = 0; eMiss = 0; ePg = 0; eSz = 0; eSh = 0;
        mPhase = 1;
      end else if (mPhase == 1 && idValid) begin
        mId = int'(idData);
        jedModel(mId, 0, kn, ns, a, b, c);
        if ((mId >> 16) != 'h1F || ns) mPhase = 2;
        else begin
          pend = 1; pMiss = !kn; pPg = kn ? a : 0; pSz = kn ? b : 0; pSh = kn ? c : 0;
          mPhase = 3;
        end
      end else if (mPhase == 2 && statValid) begin
        if ((mId >> 16) != 'h1F) begin
          ok = legModel(int'(statData), a, b, c);
          pMiss = !ok;
        end else begin
          jedModel(mId, int'(statData), kn, ns, a, b, c);
          pMiss = 0;
        end
        pPg = a; pSz = b; pSh = c; pend = 1; mPhase = 3;
      end
      if (doPend) begin
        mPhase = 0;
        if (pMiss) eMiss = 1;
        else begin eVal = 1; ePg = pPg; eSz = pSz; eSh = pSh; end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk(geoValid == eVal, curTag, "geoValid", int'(geoValid), int'(eVal));
      chk(notFound == eMiss, curTag, "notFound", int'(notFound), int'(eMiss));
      chk(int'(pageCount) == ePg, curTag, "pageCount", int'(pageCount), ePg);
      chk(int'(pageSize) == eSz, curTag, "pageSize", int'(pageSize), eSz);
      chk(int'(addrShift) == eSh, curTag, "addrShift", int'(addrShift), eSh);
      if (idReq) chk(mPhase == 1, "R2", "idReq phase", mPhase, 1);
      if (statReq) chk(mPhase == 2, "R4", "statReq phase", mPhase, 2);
    end
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  int statSeen;

  task automatic runId(input logic [23:0] id, input logic [7:0] st, input string tag,
                       input bit pokeStart);
    curTag = tag;
    statSeen = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!idReq) @(negedge clk);
    @(negedge clk);
    if (pokeStart) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idValid = 1'b1; idData = id;
    @(negedge clk); idValid = 1'b0; idData = '0;
    for (int k = 0; k < 12; k++) begin
      if (geoValid || notFound) break;
      if (statReq) begin
        statSeen++;
        @(negedge clk);
        if (pokeStart) start = 1'b1;
        statValid = 1'b1; statData = st;
        @(negedge clk); statValid = 1'b0; statData = '0; start = 1'b0;
      end else @(negedge clk);
    end
  endtask

  task automatic expectGeo(input string req, input int pg, input int sz, input int sh, input int nStat);
    chk(geoValid && !notFound, req, "geoValid", int'(geoValid), 1);
    chk(int'(pageCount) == pg && int'(pageSize) == sz && int'(addrShift) == sh, req,
        "pages*1e6+size*100+shift", int'(pageCount) * 1000000 + int'(pageSize) * 100 + int'(addrShift),
        pg * 1000000 + sz * 100 + sh);
    chk(statSeen == nStat, req, "status reads", statSeen, nStat);
  endtask

  task automatic expectMiss(input string req, input int nStat);
    chk(notFound && !geoValid, req, "notFound", int'(notFound), 1);
    chk(statSeen == nStat, req, "status reads", statSeen, nStat);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!geoValid && !notFound && !idReq && !statReq && pageCount == 0 && pageSize == 0 && addrShift == 0,
        "R1", "reset outputs", int'(geoValid | notFound | idReq | statReq), 0);
    rstN = 1'b1;
    @(negedge clk);

    runId(24'h1F2700, 8'h01, "R3", 0); expectGeo("R3", 8192, 528, 10, 0);
    runId(24'h1F2600, 8'h01, "R4", 0); expectGeo("R4", 4096, 512, 9, 1);
    runId(24'h1F2600, 8'hAC, "R4", 0); expectGeo("R4", 4096, 528, 10, 1);
    runId(24'h1F2200, 8'h03, "R5", 0); expectGeo("R5", 512, 256, 8, 1);
    runId(24'h1F2300, 8'h00, "R5", 0); expectGeo("R5", 1024, 264, 9, 1);
    runId(24'h1F2400, 8'h81, "R5", 0); expectGeo("R5", 2048, 256, 8, 1);
    runId(24'h1F2500, 8'h80, "R5", 0); expectGeo("R5", 4096, 264, 9, 1);
    runId(24'h1F2701, 8'h01, "R5", 0); expectGeo("R5", 8192, 512, 9, 1);
    runId(24'h1F2800, 8'hBC, "R5", 0); expectGeo("R5", 8192, 1056, 11, 1);
    runId(24'h1F2800, 8'hBD, "R5", 0); expectGeo("R5", 8192, 1024, 10, 1);
    runId(24'h1F4400, 8'h01, "R6", 0); expectMiss("R6", 0);
    runId(24'h1F2702, 8'h01, "R6", 0); expectMiss("R6", 0);

    runId(24'h000000, 8'h8C, "R7", 0); expectGeo("R7", 512, 264, 9, 1);
    runId(24'h1E2600, 8'h94, "R7", 0); expectGeo("R7", 1024, 264, 9, 1);
    runId(24'hFFFFFF, 8'h9C, "R7", 0); expectGeo("R7", 2048, 264, 9, 1);
    runId(24'h000000, 8'hA4, "R7", 0); expectGeo("R7", 4096, 264, 9, 1);
    runId(24'h000000, 8'hAD, "R7", 0); expectGeo("R7", 4096, 528, 10, 1);
    runId(24'h000000, 8'hB4, "R7", 0); expectGeo("R7", 8192, 528, 10, 1);
    runId(24'h000000, 8'hB8, "R7", 0); expectGeo("R7", 8192, 1056, 11, 1);
    runId(24'h000000, 8'hBF, "R7", 0); expectGeo("R7", 8192, 1056, 11, 1);
    runId(24'h000000, 8'h00, "R8", 0); expectMiss("R8", 1);
    runId(24'h000000, 8'hFF, "R8", 0); expectMiss("R8", 1);
    runId(24'h000000, 8'h90, "R9", 0); expectMiss("R9", 1);
    runId(24'h000000, 8'h84, "R9", 0); expectMiss("R9", 1);

    // R10: start while busy is ignored
    runId(24'h1F2600, 8'h00, "R10", 1); expectGeo("R10", 4096, 528, 10, 1);
    // R10: stray answers while idle leave the held result untouched
    curTag = "R10";
    @(negedge clk); statValid = 1'b1; statData = 8'h01; idValid = 1'b1; idData = 24'h1F2200;
    @(negedge clk); statValid = 1'b0; idValid = 1'b0;
    repeat (4) @(negedge clk);
    chk(geoValid && pageSize == 528 && addrShift == 10 && !idReq, "R10", "held pageSize", int'(pageSize), 528);
    // R11: exactly one flag after completion
    chk(geoValid != notFound, "R11", "flag exclusivity", int'(geoValid) + int'(notFound), 1);
    // R2: a new start clears the result on the accepting edge
    curTag = "R2";
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!geoValid && !notFound && pageCount == 0 && idReq, "R2", "cleared with idReq", int'(geoValid), 0);
    @(negedge clk);
    chk(!idReq, "R2", "idReq single cycle", int'(idReq), 0);
    @(negedge clk); idValid = 1'b1; idData = 24'h1F2700;
    @(negedge clk); idValid = 1'b0;
    @(negedge clk);
    chk(geoValid && pageCount == 8192, "R11", "one edge after id", int'(pageCount), 8192);
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule